// File: doc/BRIEF.md
# Low-Power-Aware Watchdog Timer

This block is a watchdog timer for a small microcontroller. Software arms it once with a strobe, and it must then be serviced periodically. If the count reaches the programmed timeout, the block emits a chip-reset pulse of fixed width and starts counting again from zero. The timeout is a power of two, chosen by a 3-bit select field in the low bits of an 8-bit write-only configuration port.

The block also follows the chip's low-power states. While power-down is active, the clock is treated as stopped, so the count is frozen. Power-down can end in two ways:
- A hardware reset leaves the watchdog disarmed.
- A level-sensitive, active-low wake interrupt. In this case counting stays held off until the wake line, passed through a synchronizer, is seen high again. This keeps a long wake pulse from causing a spurious timeout.

In idle mode the clock keeps running, so the watchdog counts as usual.

Top module: `wdog_lpm`

## Requirements
- R1: After `rst_n` is released, `wdt_rst` is low and the watchdog is disarmed; with no `en_req` pulse, `wdt_rst` never rises.
- R2: An `en_req` pulse arms the watchdog permanently (only `rst_n` disarms it); further `en_req` pulses neither restart nor stop the count, and with no servicing `wdt_rst` rises after the T-th clock edge following the arming edge.
- R3: The timeout is T = 2^(BASE_EXP+S) cycles, where S = `cfg_wdata[2:0]` captured on an edge with `cfg_we` high; `cfg_wdata[7:3]` are ignored, and S is 0 after reset.
- R4: A `svc_strobe` pulse while armed clears the count, so `wdt_rst` rises after the T-th edge following the strobe edge.
- R5: Each overflow drives `wdt_rst` high for exactly RST_CYCLES (default 4) consecutive cycles, and the count restarts at zero, so successive pulses start T cycles apart.
- R6: While `pd_mode` is high the count neither advances nor overflows and keeps its value; if the wake line is already high when `pd_mode` falls, counting resumes one edge later from the kept value.
- R7: If `wake_n` is low when `pd_mode` falls, counting stays held for as long as `wake_n` stays low; after `wake_n` goes high, the SYNC_STAGES (default 2) synchronizer delay plus one release edge pass before counting restarts, giving the first `wdt_rst` rise T+3 edges after the first edge that samples `wake_n` high.
- R8: A hardware reset applied during power-down leaves the watchdog disarmed after release: no `wdt_rst` pulse follows.
- R9: `idle_mode` has no effect on counting; the timeout during idle equals T.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| svc_strobe | input | 1 | One-cycle service pulse that clears the count |
| en_req | input | 1 | One-cycle pulse that arms the watchdog (sticky) |
| cfg_we | input | 1 | Write strobe for the duration register |
| cfg_wdata | input | REG_W (8) | Write data; bits [2:0] hold the duration select |
| pd_mode | input | 1 | Power-down active (clock considered stopped) |
| idle_mode | input | 1 | Idle mode active (clock running) |
| wake_n | input | 1 | Level-sensitive wake interrupt, active low, asynchronous |
| wdt_rst | output | 1 | Chip-reset pulse, RST_CYCLES cycles wide |

## Verification
A wrong internal state shows up at the ports as a `wdt_rst` rise on the wrong edge:
- A count that keeps running in power-down, or is released while the wake line is still low, moves the rise earlier by the number of cycles spent frozen or held.
- A hold-off that never clears suppresses the rise altogether.
- A limit decoded from the wrong select bits scales the period by a power of two.
- A lost enable after reset, or one that survives a reset, turns an expected pulse into silence, or silence into a pulse.

Every case is therefore seen within one timeout period, and the bench measures the exact edge count from a known arming, service or wake edge.

// File: rtl/wdog_lpm_pkg.sv
package wdog_lpm_pkg;

   // Gating state for the watchdog count
   typedef enum logic [1:0] {
      GATE_OFF    = 2'd0,   // disarmed since reset
      GATE_RUN    = 2'd1,   // armed, counting
      GATE_FROZEN = 2'd2,   // armed, power-down active
      GATE_HOLD   = 2'd3    // armed, power-down left, waiting for wake high
   } gate_state_e;

   // Count width able to hold the longest timeout minus one
   function automatic int unsigned count_bits(input int unsigned base_exp,
                                              input int unsigned sel_w);
      return base_exp + (1 << sel_w) - 1;
   endfunction

endpackage

// File: rtl/wdog_wake_sync.sv
module wdog_wake_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   generate
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RESET_VAL;
            else        q <= async_in;
         end
         assign sync_out = q;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= {STAGES{RESET_VAL}};
            else        sr <= {sr[STAGES-2:0], async_in};
         end
         assign sync_out = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg #(
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [SEL_W-1:0] wsel,
   output logic [SEL_W-1:0] sel
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sel <= '0;
      else if (we) sel <= wsel;
   end

endmodule

// File: rtl/wdog_gate.sv
module wdog_gate
   import wdog_lpm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en_req,
   input  logic pd_mode,
   input  logic wake_s,
   output logic advance,
   output logic en_active
);

   gate_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         GATE_OFF: begin
            if (en_req) st_d = pd_mode ? GATE_FROZEN : GATE_RUN;
         end
         GATE_RUN: begin
            if (pd_mode) st_d = GATE_FROZEN;
         end
         GATE_FROZEN: begin
            if (!pd_mode) st_d = wake_s ? GATE_RUN : GATE_HOLD;
         end
         GATE_HOLD: begin
            if (pd_mode)     st_d = GATE_FROZEN;
            else if (wake_s) st_d = GATE_RUN;
         end
         default: st_d = GATE_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= GATE_OFF;
      else        st_q <= st_d;
   end

   assign advance   = (st_q == GATE_RUN) && !pd_mode;
   assign en_active = (st_q != GATE_OFF);

endmodule

// File: rtl/wdog_count.sv
module wdog_count
   import wdog_lpm_pkg::*;
#(
   parameter int unsigned BASE_EXP = 14,
   parameter int unsigned SEL_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic             clear,
   input  logic [SEL_W-1:0] sel,
   output logic             ovf
);

   localparam int unsigned CNT_W = count_bits(BASE_EXP, SEL_W);
   localparam logic [SEL_W-1:0] SEL_TOP = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;
   logic [SEL_W-1:0] shamt;
   logic             at_lim;

   // Limit is 2^(BASE_EXP+sel)-1: all-ones shifted right by the unused selects
   assign shamt  = SEL_TOP - sel;
   assign lim    = {CNT_W{1'b1}} >> shamt;
   // >= so that shrinking the select mid-count still overflows promptly
   assign at_lim = (cnt_q >= lim);
   assign ovf    = advance && !clear && at_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clear)   cnt_q <= '0;
      else if (advance) cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
   end

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
   parameter int unsigned CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse
);

   generate
      if (CYCLES == 1) begin : g_one
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= fire;
         end
         assign pulse = q;
      end else begin : g_stretch
         localparam int unsigned CW = $clog2(CYCLES + 1);
         localparam logic [CW-1:0] LOAD = CW'(CYCLES);
         logic [CW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            left_q <= '0;
            else if (fire)         left_q <= LOAD;
            else if (left_q != '0) left_q <= left_q - 1'b1;
         end
         assign pulse = (left_q != '0);
      end
   endgenerate

endmodule

// File: rtl/wdog_lpm.sv
module wdog_lpm #(
   parameter int unsigned REG_W       = 8,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned BASE_EXP    = 14,
   parameter int unsigned RST_CYCLES  = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             svc_strobe,
   input  logic             en_req,
   input  logic             cfg_we,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             pd_mode,
   input  logic             idle_mode,
   input  logic             wake_n,
   output logic             wdt_rst
);

   generate
      if (BASE_EXP < 1 || SEL_W < 1 || REG_W <= SEL_W || RST_CYCLES < 1 ||
          SYNC_STAGES < 1 || (2 ** BASE_EXP) <= RST_CYCLES) begin : g_param_bad
         $error("wdog_lpm: parameter set out of range");
      end
   endgenerate

   logic             wake_s;
   logic             advance;
   logic             en_active;
   logic             ovf;
   logic [SEL_W-1:0] sel;
   logic             svc_clear;
   logic             lint_unused;

   // Idle keeps the clock running, so it does not gate counting;
   // reserved register bits are dropped.
   assign lint_unused = idle_mode ^ (^cfg_wdata[REG_W-1:SEL_W]);

   assign svc_clear = svc_strobe && en_active;

   wdog_wake_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (wake_n),
      .sync_out (wake_s)
   );

   wdog_cfg #(
      .SEL_W (SEL_W)
   ) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wsel  (cfg_wdata[SEL_W-1:0]),
      .sel   (sel)
   );

   wdog_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_req    (en_req),
      .pd_mode   (pd_mode),
      .wake_s    (wake_s),
      .advance   (advance),
      .en_active (en_active)
   );

   wdog_count #(
      .BASE_EXP (BASE_EXP),
      .SEL_W    (SEL_W)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (advance),
      .clear   (svc_clear),
      .sel     (sel),
      .ovf     (ovf)
   );

   wdog_pulse #(
      .CYCLES (RST_CYCLES)
   ) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (ovf),
      .pulse (wdt_rst)
   );

endmodule

// File: rtl/wdog_lpm_chk.sv
module wdog_lpm_chk #(
   parameter int unsigned RST_CYCLES = 4
) (
   input logic clk,
   input logic rst_n,
   input logic svc_strobe,
   input logic pd_mode,
   input logic en_active,
   input logic wdt_rst
);

   localparam int unsigned HW = $clog2(RST_CYCLES + 2) + 1;
   logic [HW-1:0] hi_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   hi_len <= '0;
      else if (!wdt_rst)            hi_len <= '0;
      else if (hi_len != '1)        hi_len <= hi_len + 1'b1;
   end

   // R1: disarmed watchdog stays silent
   p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en_active |-> !wdt_rst);

   // R2: arming is sticky
   p_sticky_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en_active |=> en_active);

   // R4: no overflow within two edges of a service strobe
   p_svc_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_rst) |-> (!$past(svc_strobe) && !$past(svc_strobe, 2)));

   // R5: pulse is exactly RST_CYCLES long
   p_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdt_rst) |-> (hi_len == HW'(RST_CYCLES)));

   // R6: no overflow launched while in power-down
   p_pd_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_rst) |-> !$past(pd_mode));

endmodule

bind wdog_lpm wdog_lpm_chk #(
   .RST_CYCLES (RST_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .svc_strobe (svc_strobe),
   .pd_mode    (pd_mode),
   .en_active  (en_active),
   .wdt_rst    (wdt_rst)
);

// File: tb/test_wdog_lpm.sv
`timescale 1ns/1ps
module test_wdog_lpm;

   localparam int unsigned BASE_EXP = 4;
   localparam int T0 = 16;   // 2^BASE_EXP

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       svc_strobe = 1'b0;
   logic       en_req = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic       pd_mode = 1'b0;
   logic       idle_mode = 1'b0;
   logic       wake_n = 1'b1;
   logic       wdt_rst;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   wdog_lpm #(
      .BASE_EXP (BASE_EXP)
   ) i_wdog_lpm (
      .clk        (clk),
      .rst_n      (rst_n),
      .svc_strobe (svc_strobe),
      .en_req     (en_req),
      .cfg_we     (cfg_we),
      .cfg_wdata  (cfg_wdata),
      .pd_mode    (pd_mode),
      .idle_mode  (idle_mode),
      .wake_n     (wake_n),
      .wdt_rst    (wdt_rst)
   );

   // Stimulus/expectation table: register write value -> edges to overflow (R3)
   localparam int VEC_N = 5;
   localparam logic [7:0] VEC_WDATA [VEC_N] = '{8'h00, 8'h01, 8'hFA, 8'h03, 8'hF7};
   localparam int         VEC_EXP   [VEC_N] = '{16, 32, 64, 128, 2048};

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; svc_strobe = 1'b0; en_req = 1'b0; cfg_we = 1'b0;
      cfg_wdata = 8'h00; pd_mode = 1'b0; idle_mode = 1'b0; wake_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic arm();
      en_req = 1'b1;
      @(negedge clk);
      en_req = 1'b0;
   endtask

   task automatic write_cfg(input logic [7:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0; cfg_wdata = 8'h00;
   endtask

   // Counts edges until a low-to-high change of wdt_rst; n=-1 if none in limit.
   // hi counts high samples seen before that change.
   task automatic measure(input int limit, output int n, output int hi);
      logic prev;
      bit   done;
      prev = wdt_rst; done = 1'b0; n = 0; hi = 0;
      while (!done && n < limit) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (wdt_rst && !prev) done = 1'b1;
         else begin
            if (wdt_rst) hi++;
            prev = wdt_rst;
         end
      end
      if (!done) n = -1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int n;
      int hi;

      // R1: reset state and silence while disarmed
      do_reset();
      check("R1 reset wdt_rst", int'(wdt_rst), 0);
      measure(100, n, hi);
      check("R1 no pulse while disarmed", n, -1);

      // R3: duration table walk (also R2 plain arming)
      for (int i = 0; i < VEC_N; i++) begin
         do_reset();
         write_cfg(VEC_WDATA[i]);
         arm();
         measure(4096, n, hi);
         check($sformatf("R3 timeout for wdata=%02h", VEC_WDATA[i]), n, VEC_EXP[i]);
      end

      // R3: select resets to 000
      do_reset();
      arm();
      measure(4096, n, hi);
      check("R3 reset select gives 2^BASE_EXP", n, T0);

      // R5: restart period and pulse width
      measure(200, n, hi);
      check("R5 period between pulses", n, T0);
      check("R5 pulse width", hi + 1, 4);

      // R2: re-arming mid-count neither restarts nor stops
      do_reset();
      arm();
      repeat (5) @(negedge clk);
      arm();
      measure(200, n, hi);
      check("R2 extra en_req ignored", n, T0 - 6);

      // R4: service clears count
      do_reset();
      arm();
      repeat (10) @(negedge clk);
      svc_strobe = 1'b1;
      @(negedge clk);
      svc_strobe = 1'b0;
      measure(200, n, hi);
      check("R4 overflow T after service", n, T0);

      // R9: idle mode counts normally
      do_reset();
      idle_mode = 1'b1;
      arm();
      measure(200, n, hi);
      check("R9 idle timeout", n, T0);

      // R6: power-down freeze keeps count
      do_reset();
      arm();
      repeat (5) @(negedge clk);
      pd_mode = 1'b1;
      measure(40, n, hi);
      check("R6 no pulse in power-down", n + hi, -1);
      pd_mode = 1'b0;
      measure(200, n, hi);
      check("R6 resume from kept count", n, T0 - 5 + 1);

      // R7: hold-off while wake line low after power-down exit
      do_reset();
      arm();
      pd_mode = 1'b1;
      wake_n = 1'b0;
      repeat (30) @(negedge clk);
      pd_mode = 1'b0;
      measure(60, n, hi);
      check("R7 held while wake low", n + hi, -1);
      wake_n = 1'b1;
      measure(200, n, hi);
      check("R7 restart after wake release", n, T0 + 3);

      // R8: reset during power-down leaves watchdog disarmed
      do_reset();
      arm();
      pd_mode = 1'b1;
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      pd_mode = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 wdt_rst low after reset wake", int'(wdt_rst), 0);
      measure(100, n, hi);
      check("R8 disarmed after reset wake", n, -1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule